// File: doc/BRIEF.md
# Exception and Event Interrupt Arbiter

This block sits beside a processor core's sequencer. In every cycle it decides whether the core must enter an interrupt sequence at the next instruction boundary, and which vector to use. There are two kinds of request. Exceptions cannot be masked. They are latched and served in a fixed precedence order, and the non-maskable external interrupt takes its place in that same order. Event interrupts are level requests, each with its own 4-bit priority. One is served only when its priority is strictly above the execution priority that the core reports from its status word.

Two exception sources are detected inside the block. The first is a stack pointer that crosses below a fixed limit: it fires once per crossing, not while the pointer stays low. The second is a return-from-interrupt executed in user mode. The other exception sources are single-cycle request pulses. The output is a valid/ready handshake. `take` is the valid and `core_rdy` is the ready, which the core raises at an instruction boundary. `take` is never high without `core_rdy`, and each cycle with `take` high consumes exactly one interrupt. While `core_rdy` is low, nothing is taken, all pending exceptions are held, and new exception requests keep latching. Event requests are not stored: their source must hold them until they are served.

Top module: `irq_arbiter`

## Requirements
- R1: Exceptions ignore `cur_pri` and are taken whatever its value, even when it is all ones. A pending exception always wins over any event. When an exception is taken, `new_pri` is all ones (15).
- R2: An event request is eligible only when its priority is strictly greater than `cur_pri`. When the priorities are equal, the request is not taken.
- R3: Among eligible events, the highest priority wins, and among equal priorities the lowest source index wins. On an event take, `vec` = 16 + source index and `new_pri` = that source's priority.
- R4: Exception vector codes are breakpoint 1, trace 2, stack overflow 3, divide-by-zero 4, user-mode return 5 and non-maskable interrupt 6. Codes 0 and 7 to 15 are never produced. When several are pending, they are taken in that order, lowest code first.
- R5: An exception request is eligible in the cycle it is raised. One that is not taken stays pending until it is taken.
- R6: A stack overflow exception is raised when `sp` is below 0x0080 in a cycle where it was at or above 0x0080 in the previous cycle. It is not raised again while `sp` stays below 0x0080.
- R7: `reti_exec` raises the user-mode return exception only while `user_mode` is 1. With `user_mode` at 0 it has no effect.
- R8: `take` is high only in a cycle where `core_rdy` is high. With `core_rdy` low, pending exceptions are kept. When `take` is low, `vec` and `new_pri` are 0.
- R9: Reset clears all pending exceptions and disarms the stack detector. A pointer that is already below the limit when reset ends raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_rdy | input | 1 | Core is at an instruction boundary and accepts an interrupt |
| brk_req | input | 1 | Breakpoint exception request pulse |
| trace_req | input | 1 | Trace exception request pulse |
| div0_req | input | 1 | Divide-by-zero exception request pulse |
| nmi_req | input | 1 | Non-maskable external interrupt request pulse |
| reti_exec | input | 1 | Core is executing a return-from-interrupt |
| user_mode | input | 1 | Core runs in user mode |
| sp | input | 16 | Current stack pointer |
| evt_req | input | 8 | Event interrupt request levels, one per source |
| evt_pri | input | 32 | Event priorities, 4 bits per source, source 0 in bits 3:0 |
| cur_pri | input | 4 | Execution priority from the status word |
| take | output | 1 | Interrupt entry strobe (valid) |
| vec | output | 5 | Vector code of the interrupt taken |
| new_pri | output | 4 | Execution priority to load on entry |

## Verification
The bench targets several boundary cases, each with the failure it would expose:
- An event priority exactly equal to `cur_pri` must be refused. An off-by-one comparison would take it.
- Two sources share the top priority. A loop that scans in the wrong direction would pick the higher index.
- Three exceptions are latched while `core_rdy` is low. They must then come out one per cycle in precedence order, ahead of a waiting event. A design that drops the losers or lets the event go first fails here.
- The stack pointer is walked onto the limit, across it, further down, back up and across again. A level detector would refire while the pointer stays low, and a `<=` comparison would fire at the limit itself.
- Reset is applied while an exception is pending and with the pointer already low. Leftover state would show up as a spurious take.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Exception sources, in precedence order (index 0 is taken first).
  localparam int EXC_N   = 6;
  localparam int EXC_BRK = 0;
  localparam int EXC_TRC = 1;
  localparam int EXC_STK = 2;
  localparam int EXC_DIV = 3;
  localparam int EXC_URT = 4;
  localparam int EXC_NMI = 5;
  // Vector space: codes below EVT_BASE are exceptions, events start at EVT_BASE.
  localparam int EVT_BASE = 16;
endpackage

// File: rtl/irq_exc_latch.sv
module irq_exc_latch
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXC_N-1:0] raw,
  input  logic             ack_en,
  output logic             any,
  output logic [EXC_N-1:0] grant
);
  logic [EXC_N-1:0] pend_q;
  logic [EXC_N-1:0] cand;
  logic [EXC_N-1:0] pend_d;

  always_comb begin
    cand  = pend_q | raw;
    grant = '0;
    for (int i = EXC_N - 1; i >= 0; i--) begin
      if (cand[i]) grant = EXC_N'(1) << i;
    end
    any    = |cand;
    pend_d = cand & ~(ack_en ? grant : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4

  for (genvar g = 0; g < EXC_N; g++) begin : g_chk
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cand[g] && !(ack_en && grant[g])) |=> pend_q[g]); // R5
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && grant[g]) |=> !pend_q[g]); // R5
  end
endmodule

// File: rtl/irq_stk_watch.sv
module irq_stk_watch #(
  parameter int          SP_W  = 16,
  parameter logic [15:0] LIMIT = 16'h0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SP_W-1:0] sp,
  output logic            fire
);
  localparam logic [SP_W-1:0] LIM = SP_W'(LIMIT);

  logic armed_q;
  logic above;

  assign above = (sp >= LIM);
  assign fire  = armed_q && !above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= above;
  end

  AST_STK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R6
  AST_STK_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (sp < LIM)); // R6
endmodule

// File: rtl/irq_evt_sel.sv
module irq_evt_sel #(
  parameter int N  = 8,
  parameter int PW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic [N*PW-1:0]      pri,
  input  logic [PW-1:0]        cur,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx,
  output logic [PW-1:0]        wpri
);
  localparam int IW = $clog2(N);

  logic [N-1:0] elig;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      elig[i] = req[i] && (pri[i*PW +: PW] > cur);
    end
    any  = 1'b0;
    idx  = '0;
    wpri = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || pri[i*PW +: PW] > wpri)) begin
        any  = 1'b1;
        idx  = IW'(i);
        wpri = pri[i*PW +: PW];
      end
    end
  end

  AST_EVT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (wpri > cur)); // R2
  AST_EVT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]); // R3
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int          N_EVT    = 8,
  parameter int          PRI_W    = 4,
  parameter int          SP_W     = 16,
  parameter logic [15:0] SP_LIMIT = 16'h0080
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_rdy,
  input  logic                     brk_req,
  input  logic                     trace_req,
  input  logic                     div0_req,
  input  logic                     nmi_req,
  input  logic                     reti_exec,
  input  logic                     user_mode,
  input  logic [SP_W-1:0]          sp,
  input  logic [N_EVT-1:0]         evt_req,
  input  logic [N_EVT*PRI_W-1:0]   evt_pri,
  input  logic [PRI_W-1:0]         cur_pri,
  output logic                     take,
  output logic [$clog2(EVT_BASE+N_EVT)-1:0] vec,
  output logic [PRI_W-1:0]         new_pri
);
  localparam int VEC_W = $clog2(EVT_BASE + N_EVT);
  localparam int IW    = $clog2(N_EVT);

  logic             stk_fire;
  logic [EXC_N-1:0] exc_raw;
  logic             exc_any;
  logic [EXC_N-1:0] exc_grant;
  logic             evt_any;
  logic [IW-1:0]    evt_idx;
  logic [PRI_W-1:0] evt_wpri;
  logic [VEC_W-1:0] exc_code;

  irq_stk_watch #(.SP_W(SP_W), .LIMIT(SP_LIMIT)) u_stk (
    .clk(clk), .rst_n(rst_n), .sp(sp), .fire(stk_fire)
  );

  always_comb begin
    exc_raw          = '0;
    exc_raw[EXC_BRK] = brk_req;
    exc_raw[EXC_TRC] = trace_req;
    exc_raw[EXC_STK] = stk_fire;
    exc_raw[EXC_DIV] = div0_req;
    exc_raw[EXC_URT] = reti_exec && user_mode;
    exc_raw[EXC_NMI] = nmi_req;
  end

  irq_exc_latch u_exc (
    .clk(clk), .rst_n(rst_n), .raw(exc_raw), .ack_en(core_rdy),
    .any(exc_any), .grant(exc_grant)
  );

  irq_evt_sel #(.N(N_EVT), .PW(PRI_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .req(evt_req), .pri(evt_pri), .cur(cur_pri),
    .any(evt_any), .idx(evt_idx), .wpri(evt_wpri)
  );

  // Exception code = precedence index + 1.
  always_comb begin
    exc_code = '0;
    for (int i = 0; i < EXC_N; i++) begin
      if (exc_grant[i]) exc_code = VEC_W'(i + 1);
    end
  end

  always_comb begin
    take    = core_rdy && (exc_any || evt_any);
    vec     = '0;
    new_pri = '0;
    if (take) begin
      if (exc_any) begin
        vec     = exc_code;
        new_pri = '1;
      end else begin
        vec     = VEC_W'(EVT_BASE) + VEC_W'(evt_idx);
        new_pri = evt_wpri;
      end
    end
  end

  AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exc_any) |-> (vec < VEC_W'(EVT_BASE))); // R1
  AST_EVT_PRI_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec >= VEC_W'(EVT_BASE)) |-> (new_pri > cur_pri)); // R2
  AST_RDY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rdy && exc_any) |=> exc_any); // R8
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_rdy = 1'b0;
  logic        brk_req = 1'b0, trace_req = 1'b0, div0_req = 1'b0, nmi_req = 1'b0;
  logic        reti_exec = 1'b0, user_mode = 1'b0;
  logic [15:0] sp = 16'h0100;
  logic [7:0]  evt_req = 8'h00;
  logic [31:0] evt_pri;
  logic [3:0]  cur_pri = 4'd0;
  logic        take;
  logic [4:0]  vec;
  logic [3:0]  new_pri;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Source priorities: s0=0 s1=3 s2=1 s3=9 s4=2 s5=9 s6=5 s7=5
  assign evt_pri = {4'd5, 4'd5, 4'd9, 4'd2, 4'd9, 4'd1, 4'd3, 4'd0};

  always #4 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .core_rdy(core_rdy),
    .brk_req(brk_req), .trace_req(trace_req), .div0_req(div0_req),
    .nmi_req(nmi_req), .reti_exec(reti_exec), .user_mode(user_mode),
    .sp(sp), .evt_req(evt_req), .evt_pri(evt_pri), .cur_pri(cur_pri),
    .take(take), .vec(vec), .new_pri(new_pri)
  );

  // Row: flags{brk,trc,div0,nmi,reti,umode,rdy}, sp, evt_req, cur_pri, exp take, vec, pri
  localparam int ROWS = 27;
  localparam logic [44:0] TBL [ROWS] = '{
    {7'b0000001, 16'h0100, 8'h00, 4'd0,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h0100, 8'h04, 4'd1,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h0100, 8'h04, 4'd0,  1'b1, 5'd18, 4'd1},
    {7'b0000001, 16'h0100, 8'h2A, 4'd2,  1'b1, 5'd19, 4'd9},
    {7'b0000001, 16'h0100, 8'h2A, 4'd9,  1'b0, 5'd0,  4'd0},
    {7'b0000000, 16'h0100, 8'h80, 4'd4,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h0100, 8'h80, 4'd4,  1'b1, 5'd23, 4'd5},
    {7'b1011000, 16'h0100, 8'h80, 4'd0,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h0100, 8'h80, 4'd0,  1'b1, 5'd1,  4'd15},
    {7'b0000001, 16'h0100, 8'h80, 4'd0,  1'b1, 5'd4,  4'd15},
    {7'b0000001, 16'h0100, 8'h80, 4'd0,  1'b1, 5'd6,  4'd15},
    {7'b0000001, 16'h0100, 8'h80, 4'd0,  1'b1, 5'd23, 4'd5},
    {7'b0100101, 16'h0100, 8'h00, 4'd0,  1'b1, 5'd2,  4'd15},
    {7'b0000111, 16'h0100, 8'h00, 4'd0,  1'b1, 5'd5,  4'd15},
    {7'b0000001, 16'h0080, 8'h00, 4'd0,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h007F, 8'h00, 4'd0,  1'b1, 5'd3,  4'd15},
    {7'b0000001, 16'h0070, 8'h00, 4'd0,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h0060, 8'h00, 4'd0,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h0100, 8'h00, 4'd0,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h007E, 8'h00, 4'd0,  1'b1, 5'd3,  4'd15},
    {7'b0100001, 16'h0100, 8'h20, 4'd15, 1'b1, 5'd2,  4'd15},
    {7'b0000001, 16'h0100, 8'h20, 4'd15, 1'b0, 5'd0,  4'd0},
    {7'b0100110, 16'h0010, 8'h00, 4'd0,  1'b0, 5'd0,  4'd0},
    {7'b0000001, 16'h0010, 8'h00, 4'd0,  1'b1, 5'd2,  4'd15},
    {7'b0000001, 16'h0010, 8'h00, 4'd0,  1'b1, 5'd3,  4'd15},
    {7'b0000001, 16'h0010, 8'h00, 4'd0,  1'b1, 5'd5,  4'd15},
    {7'b0000001, 16'h0010, 8'h00, 4'd0,  1'b0, 5'd0,  4'd0}
  };

  function automatic string row_req(int r);
    case (r)
      0, 1, 4:         return "R2";
      2, 3:            return "R3";
      5:               return "R8";
      6:               return "R8";
      7, 8, 9, 10, 11: return "R4/R5";
      12, 13:          return "R7";
      14, 15, 16, 17, 18, 19: return "R6";
      20, 21:          return "R1";
      default:         return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic et, logic [4:0] ev, logic [3:0] ep);
    n_chk++;
    if (take !== et || vec !== ev || new_pri !== ep) begin
      n_bad++;
      $display("FAIL %s: take/vec/pri = %0b/%0d/%0d expected %0b/%0d/%0d",
               req, take, vec, new_pri, et, ev, ep);
    end
  endtask

  task automatic drive(logic [44:0] r);
    {brk_req, trace_req, div0_req, nmi_req, reti_exec, user_mode, core_rdy} = r[44:38];
    sp      = r[37:22];
    evt_req = r[21:14];
    cur_pri = r[13:10];
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
    end
  end

  initial begin
    // R8/R9: reset state, with requests present
    brk_req  = 1'b1;
    core_rdy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2 chk("R9", 1'b0, 5'd0, 4'd0);
    brk_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      drive(TBL[r]);
      #2 chk(row_req(r), TBL[r][9], TBL[r][8:4], TBL[r][3:0]);
    end

    // R9: latch a breakpoint without ready, then reset with sp below limit
    @(negedge clk);
    drive({7'b1000000, 16'h0010, 8'h00, 4'd0, 1'b0, 5'd0, 4'd0});
    @(negedge clk);
    drive({7'b0000000, 16'h0010, 8'h00, 4'd0, 1'b0, 5'd0, 4'd0});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    core_rdy = 1'b1;
    #2 chk("R9", 1'b0, 5'd0, 4'd0);
    @(negedge clk);
    #2 chk("R9", 1'b0, 5'd0, 4'd0);

    // R6: detector works again once re-armed after reset
    @(negedge clk);
    sp = 16'h0100;
    #2 chk("R6", 1'b0, 5'd0, 4'd0);
    @(negedge clk);
    sp = 16'h0050;
    #2 chk("R6", 1'b1, 5'd3, 4'd15);

    // R1: exception beats an eligible event and ignores a maximal cur_pri
    @(negedge clk);
    sp = 16'h0100;
    div0_req = 1'b1;
    evt_req  = 8'h08;
    cur_pri  = 4'd0;
    #2 chk("R1", 1'b1, 5'd4, 4'd15);
    @(negedge clk);
    div0_req = 1'b0;
    nmi_req  = 1'b1;
    cur_pri  = 4'd15;
    #2 chk("R1", 1'b1, 5'd6, 4'd15);
    @(negedge clk);
    nmi_req  = 1'b0;
    cur_pri  = 4'd0;
    #2 chk("R3", 1'b1, 5'd19, 4'd9);

    @(negedge clk);
    finish_run();
  end
endmodule